// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers the interrupt requests of a chip's peripherals into one status word and drives a single interrupt line to the host processor. Four GPIO banks each supply a summary request. The bank logic already holds the per-pin state, so these requests are shown live. Six other peripheral sources are caught in sticky status bits, and the host clears those bits by writing ones to them. A mask register holds one enable bit per status bit and a separate global enable. No request reaches the host until software has set the global enable.

The host treats the line as rising-edge triggered. In the default pulse mode the block issues a one-cycle pulse when an enabled request becomes pending. After the host reads the status word, the block issues a fresh pulse if enabled requests are still pending, so the host does not miss work it has not yet serviced. A parameter selects a simpler level mode instead, in which the line stays high for as long as any enabled request is pending.

Top module: `irqagg_top`

## Requirements
- R1: During reset and immediately after it, `mask_o` is all zero (including the global enable), the sticky source bits of `status_o` are zero and `irq_o` is low.
- R2: Bit b of `status_o`, for b below NUM_BANKS (bits 0 to 3 by default), equals `bank_req[b]` in the same cycle and is not stored.
- R3: When `src_req[j]` is high at a clock edge, status bit NUM_BANKS+j (bit 4+j by default) is set from that edge on and stays set after the request drops.
- R4: A cycle with `wr_stat` high clears every sticky source bit NUM_BANKS+j whose `wr_data` bit at the same position is 1. Bank bits are unaffected. If `src_req[j]` is high in the same cycle, bit NUM_BANKS+j stays set.
- R5: A cycle with `wr_mask` high loads `wr_data` into `mask_o` at the next edge. Bit k of the mask (k below STAT_W, 10 by default) enables status bit k when it is 1, and bit STAT_W is the global enable.
- R6: `irq_o` is low in the cycle after any cycle in which the global enable is 0, or in which no status bit is 1 together with its mask bit.
- R7: In pulse mode, the first clock edge at which an enabled request is pending while the block is armed gives a `irq_o` pulse exactly one cycle long. The block is then disarmed until pending goes empty or the host reads the status. Reset leaves the block armed.
- R8: In pulse mode, a `rd_stat` cycle while enabled requests stay pending and the block is disarmed re-arms it, and `irq_o` pulses again two edges after that cycle.
- R9: In level mode, `irq_o` equals one cycle later whether any enabled request is pending under the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_req | input | NUM_BANKS | Live summary request from each GPIO bank |
| src_req | input | NUM_SRC | Requests from the non-GPIO peripherals, caught in sticky bits |
| wr_stat | input | 1 | Write-one-to-clear strobe for the sticky source bits |
| wr_mask | input | 1 | Load strobe for the mask register |
| wr_data | input | STAT_W+1 | Write data for both strobes |
| rd_stat | input | 1 | Marks a host read of the status word |
| status_o | output | STAT_W | Status word: banks in the low bits, sources above them |
| mask_o | output | STAT_W+1 | Mask register: per-bit enables plus global enable at the top |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
On every cycle the assertions check the following: the mask load, that sticky bits keep a request, the write-one-to-clear result with request priority, and that the line stays quiet while the global enable is off or nothing enabled is pending. They also check that a pulse never lasts two cycles in pulse mode, and that the line tracks pending in level mode. The bench's scenarios are needed to show when pulses happen: that exactly one pulse follows a new pending request, that a status read while work remains brings a second pulse at the right edge, and that the bank bits follow their inputs with no storage. A cycle-accurate model covers both modes at once, with one instance in each mode and long runs of varied stimulus.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   typedef enum logic {
      IRQ_PULSE = 1'b0,
      IRQ_LEVEL = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/irqagg_src_latch.sv
// Sticky request bits: a set request wins over a clear in the same cycle.
module irqagg_src_latch #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] held_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held_q[i] <= 1'b0;
         else if (set_i[i])
            held_q[i] <= 1'b1;
         else if (clr_i[i])
            held_q[i] <= 1'b0;
      end
   end

   assign q_o = held_q;
endmodule

// File: rtl/irqagg_mask_reg.sv
// Enable register; every bit, including the global enable, resets to zero.
module irqagg_mask_reg #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (we_i)
         en_q <= d_i;
   end

   assign q_o = en_q;
endmodule

// File: rtl/irqagg_out_gen.sv
// Host line generator: one-cycle pulses with read re-arm, or a plain level.
module irqagg_out_gen
   import irqagg_pkg::*;
#(
   parameter irq_mode_e MODE = IRQ_PULSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  logic rd_i,
   output logic irq_o
);
   logic line_q;

   if (MODE == IRQ_PULSE) begin : g_pulse
      logic armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b1;
            line_q  <= 1'b0;
         end else begin
            line_q <= pend_i & armed_q;
            if (pend_i && armed_q)
               armed_q <= 1'b0;
            else if (rd_i || !pend_i)
               armed_q <= 1'b1;
         end
      end
   end else begin : g_level
      logic rd_unused;
      assign rd_unused = rd_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            line_q <= 1'b0;
         else
            line_q <= pend_i | (rd_unused & 1'b0);
      end
   end

   assign irq_o = line_q;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int        NUM_BANKS = 4,
   parameter int        NUM_SRC   = 6,
   parameter irq_mode_e MODE      = IRQ_PULSE,
   localparam int       STAT_W    = NUM_BANKS + NUM_SRC,
   localparam int       MASK_W    = STAT_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_req,
   input  logic [NUM_SRC-1:0]   src_req,
   input  logic                 wr_stat,
   input  logic                 wr_mask,
   input  logic [MASK_W-1:0]    wr_data,
   input  logic                 rd_stat,
   output logic [STAT_W-1:0]    status_o,
   output logic [MASK_W-1:0]    mask_o,
   output logic                 irq_o
);
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("irqagg_top: NUM_BANKS must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("irqagg_top: NUM_SRC must be at least 1");
   end
   if (STAT_W > 31) begin : g_bad_width
      $error("irqagg_top: status word wider than 31 bits");
   end

   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] src_held;
   logic [STAT_W-1:0]  hit_vec;
   logic               any_hit;
   logic               pend;

   assign clr_vec = wr_stat ? wr_data[STAT_W-1:NUM_BANKS] : '0;

   irqagg_src_latch #(.WIDTH(NUM_SRC)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_req),
      .clr_i (clr_vec),
      .q_o   (src_held)
   );

   irqagg_mask_reg #(.WIDTH(MASK_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_mask),
      .d_i   (wr_data),
      .q_o   (mask_o)
   );

   assign status_o = {src_held, bank_req};

   for (genvar k = 0; k < STAT_W; k++) begin : g_hit
      assign hit_vec[k] = status_o[k] & mask_o[k];
   end

   assign any_hit = |hit_vec;
   assign pend    = any_hit & mask_o[STAT_W];

   irqagg_out_gen #(.MODE(MODE)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .rd_i   (rd_stat),
      .irq_o  (irq_o)
   );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
   import irqagg_pkg::*;
#(
   parameter int        NUM_BANKS = 4,
   parameter int        NUM_SRC   = 6,
   parameter irq_mode_e MODE      = IRQ_PULSE,
   localparam int       STAT_W    = NUM_BANKS + NUM_SRC,
   localparam int       MASK_W    = STAT_W + 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_SRC-1:0]   src_req,
   input logic                 wr_stat,
   input logic                 wr_mask,
   input logic [MASK_W-1:0]    wr_data,
   input logic [STAT_W-1:0]    status_o,
   input logic [MASK_W-1:0]    mask_o,
   input logic                 irq_o
);
   logic [NUM_SRC-1:0] src_bits;
   logic               pend_c;

   assign src_bits = status_o[STAT_W-1:NUM_BANKS];
   assign pend_c   = mask_o[STAT_W] && ((status_o & mask_o[STAT_W-1:0]) != '0);

   a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> mask_o == $past(wr_data));

   a_r3_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req != '0) |=> ((src_bits & $past(src_req)) == $past(src_req)));

   a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> ((src_bits & $past(wr_data[STAT_W-1:NUM_BANKS] & ~src_req)) == '0));

   a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_o[STAT_W] |=> !irq_o);

   a_r6_nothing_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_c |=> !irq_o);

   if (MODE == IRQ_PULSE) begin : g_pulse_chk
      a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |=> !irq_o);
   end else begin : g_level_chk
      a_r9_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
         pend_c |=> irq_o);
   end
endmodule

bind irqagg_top irqagg_chk #(
   .NUM_BANKS (NUM_BANKS),
   .NUM_SRC   (NUM_SRC),
   .MODE      (MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_req  (src_req),
   .wr_stat  (wr_stat),
   .wr_mask  (wr_mask),
   .wr_data  (wr_data),
   .status_o (status_o),
   .mask_o   (mask_o),
   .irq_o    (irq_o)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
   import irqagg_pkg::*;

   localparam int CLK_P = 10;
   localparam int NB = 4;
   localparam int NS = 6;
   localparam int SW = NB + NS;
   localparam int MW = SW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] bank_req = '0;
   logic [NS-1:0] src_req = '0;
   logic          wr_stat = 1'b0;
   logic          wr_mask = 1'b0;
   logic [MW-1:0] wr_data = '0;
   logic          rd_stat = 1'b0;

   logic [SW-1:0] status_o, status_l;
   logic [MW-1:0] mask_o, mask_l;
   logic          irq_o, irq_l;

   int total = 0;
   int bad = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irqagg_top #(.NUM_BANKS(NB), .NUM_SRC(NS), .MODE(IRQ_PULSE)) dut (
      .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .src_req(src_req),
      .wr_stat(wr_stat), .wr_mask(wr_mask), .wr_data(wr_data), .rd_stat(rd_stat),
      .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o));

   irqagg_top #(.NUM_BANKS(NB), .NUM_SRC(NS), .MODE(IRQ_LEVEL)) dut_lvl (
      .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .src_req(src_req),
      .wr_stat(wr_stat), .wr_mask(wr_mask), .wr_data(wr_data), .rd_stat(rd_stat),
      .status_o(status_l), .mask_o(mask_l), .irq_o(irq_l));

   // Behavioural reference model
   logic [NS-1:0] m_held;
   logic [MW-1:0] m_en;
   bit            m_arm, m_pulse, m_lvl;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_held  = '0;
         m_en    = '0;
         m_arm   = 1'b1;
         m_pulse = 1'b0;
         m_lvl   = 1'b0;
      end else begin
         logic [SW-1:0] st;
         bit pend;
         st   = {m_held, bank_req};
         pend = m_en[SW] && ((st & m_en[SW-1:0]) != 0);
         m_pulse = pend && m_arm;
         if (pend && m_arm) m_arm = 1'b0;
         else if (rd_stat || !pend) m_arm = 1'b1;
         m_lvl = pend;
         if (wr_stat) m_held = m_held & ~wr_data[SW-1:NB];
         m_held = m_held | src_req;
         if (wr_mask) m_en = wr_data;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && chk_on && !done) begin
         chk(status_o[NB-1:0] == bank_req, "R2 bank bits live", 32'(status_o[NB-1:0]), 32'(bank_req));
         chk(status_o[SW-1:NB] == m_held, "R3/R4 sticky source bits", 32'(status_o[SW-1:NB]), 32'(m_held));
         chk(mask_o == m_en, "R5 mask register", 32'(mask_o), 32'(m_en));
         chk(irq_o == m_pulse, "R7 pulse line", 32'(irq_o), 32'(m_pulse));
         chk(status_l == status_o, "R2/R3 level copy status", 32'(status_l), 32'(status_o));
         chk(irq_l == m_lvl, "R9 level line", 32'(irq_l), 32'(m_lvl));
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 50000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      int cnt;
      repeat (3) tick();
      @(negedge clk);
      // R1: state during reset
      chk(mask_o == '0 && mask_l == '0, "R1 mask reset", 32'(mask_o), 0);
      chk(status_o[SW-1:NB] == '0, "R1 sticky reset", 32'(status_o), 0);
      chk(!irq_o && !irq_l, "R1 line reset", 32'(irq_o), 0);
      tick();
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R6: enables set but global enable off
      bank_req = 4'b0010;
      wr_mask = 1'b1; wr_data = 11'h3FF;
      tick();
      wr_mask = 1'b0;
      cnt = 0;
      repeat (4) begin @(negedge clk); cnt += int'(irq_o) + int'(irq_l); end
      chk(cnt == 0, "R6 global enable off keeps line low", cnt, 0);

      // R7: turn on global enable, exactly one pulse
      tick();
      wr_mask = 1'b1; wr_data = 11'h7FF;
      tick();
      wr_mask = 1'b0;
      cnt = 0;
      repeat (6) begin @(negedge clk); cnt += int'(irq_o); end
      chk(cnt == 1, "R7 single pulse for new pending", cnt, 1);

      // R8: read while still pending gives a new pulse two edges later
      tick();
      rd_stat = 1'b1;
      tick();
      rd_stat = 1'b0;
      @(negedge clk);
      chk(irq_o == 1'b0, "R8 no pulse one edge after read", 32'(irq_o), 0);
      @(negedge clk);
      chk(irq_o == 1'b1, "R8 pulse two edges after read", 32'(irq_o), 1);

      // R2: bank release
      tick();
      bank_req = '0;
      tick();
      @(negedge clk);
      chk(status_o[NB-1:0] == '0, "R2 bank bits drop at once", 32'(status_o), 0);

      // R3: short source request is held
      tick();
      src_req = 6'b000100;
      tick();
      src_req = '0;
      repeat (3) tick();
      @(negedge clk);
      chk(status_o[6] == 1'b1, "R3 source bit held after request drops", 32'(status_o), 32'h40);

      // R4: write one clears; bank bits untouched
      tick();
      bank_req = 4'b1000;
      wr_stat = 1'b1; wr_data = 11'h04F;
      tick();
      wr_stat = 1'b0;
      @(negedge clk);
      chk(status_o == 10'h008, "R4 clear leaves bank bits", 32'(status_o), 32'h008);

      // R4: request wins over clear in same cycle
      tick();
      bank_req = '0;
      src_req = 6'b000001;
      wr_stat = 1'b1; wr_data = 11'h010;
      tick();
      wr_stat = 1'b0; src_req = '0;
      @(negedge clk);
      chk(status_o[4] == 1'b1, "R4 set wins over clear", 32'(status_o), 32'h10);
      tick();
      wr_stat = 1'b1; wr_data = 11'h3F0;
      tick();
      wr_stat = 1'b0;

      // R5: only source 1 enabled; source 3 stays silent
      wr_mask = 1'b1; wr_data = 11'h420;
      tick();
      wr_mask = 1'b0;
      src_req = 6'b001000;
      tick();
      src_req = '0;
      cnt = 0;
      repeat (4) begin @(negedge clk); cnt += int'(irq_o) + int'(irq_l); end
      chk(mask_o == 11'h420, "R5 mask value loaded", 32'(mask_o), 32'h420);
      chk(cnt == 0, "R5 disabled source gives no interrupt", cnt, 0);
      tick();
      src_req = 6'b000010;
      tick();
      src_req = '0;
      cnt = 0;
      repeat (4) begin @(negedge clk); cnt += int'(irq_o); end
      chk(cnt == 1, "R5 enabled source pulses once", cnt, 1);

      // Mixed stimulus, model compared every cycle
      for (int i = 0; i < 600; i++) begin
         tick();
         bank_req = NB'($urandom);
         src_req  = ($urandom % 4 == 0) ? NS'($urandom) : '0;
         wr_stat  = ($urandom % 5 == 0);
         wr_mask  = ($urandom % 9 == 0);
         wr_data  = MW'($urandom) | ((($urandom % 4) != 0) ? 11'h400 : 11'h000);
         rd_stat  = ($urandom % 3 == 0);
      end
      tick();
      bank_req = '0; src_req = '0; wr_stat = 1'b0; wr_mask = 1'b0; rd_stat = 1'b0;
      repeat (3) tick();
      summary();
   end
endmodule